// File: doc/BRIEF.md
# OFDM Transmit Frame Assembler

This block turns a stream of time-domain OFDM symbols into a complete transmit frame. On a frame request it first plays a fixed synchronisation preamble from internal constant storage. The preamble has a short section made of a repeated 16-sample pattern, followed by a long section made of a 64-sample pattern sent twice behind a 32-sample guard. It then emits each requested data symbol. Every data symbol is preceded by a cyclic prefix copied from its own tail.

Data symbols arrive as 64-sample groups of signed Q1.15 I/Q pairs on a valid/ready input. They are stored in two alternating 64-entry banks. One bank can fill while the other drains, so the output stays continuous. The output is a valid/ready stream. A frame ends by itself once the latched number of data symbols has been sent, and the block then returns to idle.

Top module: `ofdm_frame_asm`

## Requirements
- R1: After reset, and whenever no frame is in progress, out_valid_o and in_ready_o are both 0 and input samples are not taken.
- R2: The first 160 output samples of a frame are the short pattern repeated 10 times. Output sample n carries short sample k = n mod 16, where short sample k is I = 0x1000 + k and Q = 0xE000 + k.
- R3: The next 160 output samples are the long section. First come the last 32 long samples (k = 32..63), then long samples 0..63 twice. Long sample k is I = 0x4000 + k and Q = 0xC000 + k.
- R4: Each data symbol leaves as 80 samples: the input samples at positions 48..63, then all 64 input samples in arrival order. Symbols leave in arrival order.
- R5: A frame carries exactly the number of data symbols given on nsym_i when it starts, and nsym_i = 0 gives a preamble-only frame. In the cycle after the last output handshake, out_valid_o and in_ready_o are 0.
- R6: While out_valid_o is 1 and out_ready_i is 0, the output sample is held unchanged and stays valid. No sample is lost or repeated.
- R7: A start_i pulse while a frame is in progress has no effect on the frame's content or length.
- R8: With input always valid and output always ready, the whole frame leaves with no idle output cycle. This works because one bank accepts a symbol while the other is being sent.
- R9: in_ready_o falls to 0 once the frame's requested number of symbols has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request, taken only when idle |
| nsym_i | input | 8 | Number of data symbols in the requested frame |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted this cycle if valid |
| in_re_i | input | 16 | Input sample, in-phase, Q1.15 |
| in_im_i | input | 16 | Input sample, quadrature, Q1.15 |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Downstream accepts the output sample |
| out_re_o | output | 16 | Output sample, in-phase |
| out_im_o | output | 16 | Output sample, quadrature |

## Verification
A vector table runs frames with one to four symbols and a preamble-only frame. These are run under free-flowing output and under periodic back-pressure. Every output sample is compared with a position-derived expectation, which separates the short section from the guarded long section and the prefix copy from the body. Unstalled frames are also checked for idle output cycles, which exposes a buffer that cannot fill while draining. Frames that carry a mid-frame restart show whether a busy request changes the length or restarts the preamble.

// File: rtl/ofdm_asm_pkg.sv
package ofdm_asm_pkg;
  typedef enum logic [1:0] {
    SEC_IDLE,
    SEC_SHORT,
    SEC_LONG,
    SEC_DATA
  } sec_e;

  // preamble pattern bases; sample k adds k to both components
  localparam logic [15:0] SHORT_RE0 = 16'h1000;
  localparam logic [15:0] SHORT_IM0 = 16'hE000;
  localparam logic [15:0] LONG_RE0  = 16'h4000;
  localparam logic [15:0] LONG_IM0  = 16'hC000;
endpackage

// File: rtl/ofdm_pre_rom.sv
module ofdm_pre_rom #(
  parameter int SMP_W     = 16,
  parameter int SYM_LEN   = 64,
  parameter int SHORT_LEN = 16,
  localparam int AW       = $clog2(SYM_LEN)
) (
  input  logic          long_i,
  input  logic [AW-1:0] addr_i,
  output logic [SMP_W-1:0] re_o,
  output logic [SMP_W-1:0] im_o
);
  import ofdm_asm_pkg::*;

  logic [AW-1:0] short_k;
  assign short_k = AW'(int'(addr_i) % SHORT_LEN);

  always_comb begin
    if (long_i) begin
      re_o = SMP_W'(LONG_RE0) + SMP_W'(addr_i);
      im_o = SMP_W'(LONG_IM0) + SMP_W'(addr_i);
    end else begin
      re_o = SMP_W'(SHORT_RE0) + SMP_W'(short_k);
      im_o = SMP_W'(SHORT_IM0) + SMP_W'(short_k);
    end
  end
endmodule

// File: rtl/ofdm_sym_buf.sv
module ofdm_sym_buf #(
  parameter int SMP_W   = 16,
  parameter int SYM_LEN = 64,
  parameter int NSYM_W  = 8,
  localparam int AW     = $clog2(SYM_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              active_i,
  input  logic [NSYM_W-1:0] limit_i,
  input  logic              in_valid_i,
  input  logic [SMP_W-1:0]  in_re_i,
  input  logic [SMP_W-1:0]  in_im_i,
  output logic              in_ready_o,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic              rd_done_i,
  output logic              rd_full_o,
  output logic [SMP_W-1:0]  rd_re_o,
  output logic [SMP_W-1:0]  rd_im_o
);
  logic [2*SMP_W-1:0] mem_q [2*SYM_LEN];
  logic              wr_bank_q, rd_bank_q;
  logic [1:0]        full_q, full_d;
  logic [AW-1:0]     wr_cnt_q;
  logic [NSYM_W-1:0] sym_wr_q;
  logic              wr_fire, wr_last;

  assign in_ready_o = active_i && !full_q[wr_bank_q] && (sym_wr_q < limit_i);
  assign wr_fire    = in_valid_i && in_ready_o;
  assign wr_last    = wr_fire && (wr_cnt_q == AW'(SYM_LEN - 1));

  always_comb begin
    full_d = full_q;
    if (wr_last)   full_d[wr_bank_q] = 1'b1;
    if (rd_done_i) full_d[rd_bank_q] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank_q <= 1'b0;
      rd_bank_q <= 1'b0;
      full_q    <= '0;
      wr_cnt_q  <= '0;
      sym_wr_q  <= '0;
    end else if (clear_i) begin
      wr_bank_q <= 1'b0;
      rd_bank_q <= 1'b0;
      full_q    <= '0;
      wr_cnt_q  <= '0;
      sym_wr_q  <= '0;
    end else begin
      full_q <= full_d;
      if (rd_done_i) rd_bank_q <= !rd_bank_q;
      if (wr_last) begin
        wr_cnt_q  <= '0;
        wr_bank_q <= !wr_bank_q;
        sym_wr_q  <= sym_wr_q + NSYM_W'(1);
      end else if (wr_fire) begin
        wr_cnt_q <= wr_cnt_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_fire) mem_q[{wr_bank_q, wr_cnt_q}] <= {in_re_i, in_im_i};
  end

  assign rd_full_o          = full_q[rd_bank_q];
  assign {rd_re_o, rd_im_o} = mem_q[{rd_bank_q, rd_addr_i}];
endmodule

// File: rtl/ofdm_frame_seq.sv
module ofdm_frame_seq #(
  parameter int SYM_LEN    = 64,
  parameter int CP_LEN     = 16,
  parameter int SHORT_LEN  = 16,
  parameter int SHORT_REPS = 10,
  parameter int GUARD_LEN  = 32,
  parameter int LONG_REPS  = 2,
  parameter int NSYM_W     = 8,
  localparam int AW        = $clog2(SYM_LEN),
  localparam int SHORT_TOT = SHORT_LEN * SHORT_REPS,
  localparam int LONG_TOT  = GUARD_LEN + LONG_REPS * SYM_LEN,
  localparam int DATA_TOT  = CP_LEN + SYM_LEN,
  localparam int PW        = $clog2(SHORT_TOT + LONG_TOT + DATA_TOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NSYM_W-1:0] nsym_i,
  input  logic              out_ready_i,
  input  logic              buf_full_i,
  output logic              active_o,
  output logic              clear_o,
  output logic [NSYM_W-1:0] nsym_o,
  output logic              out_valid_o,
  output logic              use_buf_o,
  output logic              rom_long_o,
  output logic [AW-1:0]     addr_o,
  output logic              rd_done_o
);
  import ofdm_asm_pkg::*;

  sec_e              sec_q;
  logic [PW-1:0]     pos_q;
  logic [NSYM_W-1:0] nsym_q, sym_q;
  logic              fire, sec_end;
  int                p;

  assign p           = int'(pos_q);
  assign active_o    = (sec_q != SEC_IDLE);
  assign clear_o     = (sec_q == SEC_IDLE) && start_i;
  assign nsym_o      = nsym_q;
  assign use_buf_o   = (sec_q == SEC_DATA);
  assign rom_long_o  = (sec_q == SEC_LONG);
  assign out_valid_o = (sec_q == SEC_SHORT) || (sec_q == SEC_LONG) ||
                       ((sec_q == SEC_DATA) && buf_full_i);
  assign fire        = out_valid_o && out_ready_i;

  always_comb begin
    addr_o  = '0;
    sec_end = 1'b0;
    unique case (sec_q)
      SEC_SHORT: begin
        addr_o  = AW'(p % SHORT_LEN);
        sec_end = (p == SHORT_TOT - 1);
      end
      SEC_LONG: begin
        // guard is the tail of the long pattern
        addr_o  = (p < GUARD_LEN) ? AW'(p + SYM_LEN - GUARD_LEN)
                                  : AW'((p - GUARD_LEN) % SYM_LEN);
        sec_end = (p == LONG_TOT - 1);
      end
      SEC_DATA: begin
        addr_o  = (p < CP_LEN) ? AW'(p + SYM_LEN - CP_LEN) : AW'(p - CP_LEN);
        sec_end = (p == DATA_TOT - 1);
      end
      default: ;
    endcase
  end

  assign rd_done_o = (sec_q == SEC_DATA) && fire && sec_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= SEC_IDLE;
      pos_q  <= '0;
      nsym_q <= '0;
      sym_q  <= '0;
    end else if (sec_q == SEC_IDLE) begin
      if (start_i) begin
        sec_q  <= SEC_SHORT;
        pos_q  <= '0;
        nsym_q <= nsym_i;
        sym_q  <= '0;
      end
    end else if (fire) begin
      if (!sec_end) begin
        pos_q <= pos_q + PW'(1);
      end else begin
        pos_q <= '0;
        unique case (sec_q)
          SEC_SHORT: sec_q <= SEC_LONG;
          SEC_LONG:  sec_q <= (nsym_q == '0) ? SEC_IDLE : SEC_DATA;
          default: begin
            sym_q <= sym_q + NSYM_W'(1);
            if (sym_q == nsym_q - NSYM_W'(1)) sec_q <= SEC_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ofdm_frame_asm.sv
module ofdm_frame_asm #(
  parameter int SMP_W      = 16,
  parameter int SYM_LEN    = 64,
  parameter int CP_LEN     = 16,
  parameter int SHORT_LEN  = 16,
  parameter int SHORT_REPS = 10,
  parameter int GUARD_LEN  = 32,
  parameter int LONG_REPS  = 2,
  parameter int NSYM_W     = 8,
  localparam int AW        = $clog2(SYM_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NSYM_W-1:0] nsym_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [SMP_W-1:0]  in_re_i,
  input  logic [SMP_W-1:0]  in_im_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [SMP_W-1:0]  out_re_o,
  output logic [SMP_W-1:0]  out_im_o
);
  logic              seq_active, seq_clear, use_buf, rom_long, rd_done, buf_full;
  logic [NSYM_W-1:0] seq_nsym;
  logic [AW-1:0]     addr;
  logic [SMP_W-1:0]  rom_re, rom_im, buf_re, buf_im;

  ofdm_frame_seq #(
    .SYM_LEN(SYM_LEN), .CP_LEN(CP_LEN), .SHORT_LEN(SHORT_LEN),
    .SHORT_REPS(SHORT_REPS), .GUARD_LEN(GUARD_LEN), .LONG_REPS(LONG_REPS),
    .NSYM_W(NSYM_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .nsym_i, .out_ready_i,
    .buf_full_i (buf_full),
    .active_o   (seq_active),
    .clear_o    (seq_clear),
    .nsym_o     (seq_nsym),
    .out_valid_o,
    .use_buf_o  (use_buf),
    .rom_long_o (rom_long),
    .addr_o     (addr),
    .rd_done_o  (rd_done)
  );

  ofdm_sym_buf #(.SMP_W(SMP_W), .SYM_LEN(SYM_LEN), .NSYM_W(NSYM_W)) u_buf (
    .clk_i, .rst_ni,
    .clear_i   (seq_clear),
    .active_i  (seq_active),
    .limit_i   (seq_nsym),
    .in_valid_i, .in_re_i, .in_im_i, .in_ready_o,
    .rd_addr_i (addr),
    .rd_done_i (rd_done),
    .rd_full_o (buf_full),
    .rd_re_o   (buf_re),
    .rd_im_o   (buf_im)
  );

  ofdm_pre_rom #(.SMP_W(SMP_W), .SYM_LEN(SYM_LEN), .SHORT_LEN(SHORT_LEN)) u_rom (
    .long_i (rom_long),
    .addr_i (addr),
    .re_o   (rom_re),
    .im_o   (rom_im)
  );

  assign out_re_o = use_buf ? buf_re : rom_re;
  assign out_im_o = use_buf ? buf_im : rom_im;
endmodule

// File: rtl/ofdm_frame_asm_chk.sv
module ofdm_frame_asm_chk #(
  parameter int SMP_W  = 16,
  parameter int NSYM_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              active,
  input logic [NSYM_W-1:0] nsym_q,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [SMP_W-1:0]  out_re_o,
  input logic [SMP_W-1:0]  out_im_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (!out_valid_o && !in_ready_o));

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_re_o) && $stable(out_im_o)));

  p_busy_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && start_i) |=> $stable(nsym_q));

  p_ready_in_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> active);

  p_end_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active) |-> !out_valid_o);
endmodule

bind ofdm_frame_asm ofdm_frame_asm_chk #(.SMP_W(SMP_W), .NSYM_W(NSYM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .active      (seq_active),
  .nsym_q      (seq_nsym),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_re_o    (out_re_o),
  .out_im_o    (out_im_o)
);

// File: tb/ofdm_frame_asm_bench.sv
module ofdm_frame_asm_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  nsym_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] in_re_i = '0, in_im_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [15:0] out_re_o, out_im_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  ofdm_frame_asm u_ofdm_frame_asm (.*);

  // vector: nsym, stall period (0 = never), mid-frame restart, data seed
  typedef struct packed {
    logic [7:0]  nsym;
    logic [3:0]  stall;
    logic        restart;
    logic [15:0] seed;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'd1, 4'd0, 1'b0, 16'h1357},
    '{8'd3, 4'd0, 1'b0, 16'h2468},
    '{8'd2, 4'd3, 1'b1, 16'hA5A5},
    '{8'd0, 4'd0, 1'b0, 16'h0000},
    '{8'd4, 4'd2, 1'b0, 16'h0F0F},
    '{8'd2, 4'd0, 1'b1, 16'h7777}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] data_smp(input int s, input int k, input logic [15:0] seed);
    logic [15:0] re;
    re = seed ^ {s[7:0], k[7:0]};
    return {re, 16'(seed + {s[7:0], k[7:0]})};
  endfunction

  function automatic logic [31:0] exp_at(input int idx, input logic [15:0] seed);
    int p, s, j, k;
    if (idx < 160) begin
      k = idx % 16;
      return {16'h1000 + 16'(k), 16'hE000 + 16'(k)};
    end else if (idx < 320) begin
      p = idx - 160;
      k = (p < 32) ? p + 32 : (p - 32) % 64;
      return {16'h4000 + 16'(k), 16'hC000 + 16'(k)};
    end
    p = idx - 320;
    s = p / 80;
    j = p % 80;
    k = (j < 16) ? j + 48 : j - 16;
    return data_smp(s, k, seed);
  endfunction

  function automatic string req_of(input int idx);
    if (idx < 160) return "R2 short";
    if (idx < 320) return "R3 long";
    return "R4 data";
  endfunction

  task automatic drive_in(input vec_t v);
    bit took;
    for (int s = 0; s < int'(v.nsym); s++) begin
      for (int k = 0; k < 64; k++) begin
        {in_re_i, in_im_i} = data_smp(s, k, v.seed);
        in_valid_i = 1'b1;
        took = 1'b0;
        while (!took) begin
          took = in_ready_o;
          @(negedge clk_i);
        end
      end
    end
    check(in_ready_o == 1'b0, "R9 ready after last symbol", {31'd0, in_ready_o}, 32'd0);
  endtask

  task automatic watch_out(input vec_t v);
    int total, idx, gaps, cyc;
    bit held;
    logic [31:0] held_val;
    total = 320 + 80 * int'(v.nsym);
    idx = 0; gaps = 0; cyc = 0; held = 1'b0;
    while (idx < total) begin
      out_ready_i = (v.stall == 0) ? 1'b1 : ((cyc % int'(v.stall)) != 0);
      if (held)
        check(out_valid_o && {out_re_o, out_im_o} == held_val, "R6 stall hold",
              {out_re_o, out_im_o}, held_val);
      held = 1'b0;
      if (out_valid_o) begin
        if (out_ready_i) begin
          check({out_re_o, out_im_o} == exp_at(idx, v.seed), req_of(idx),
                {out_re_o, out_im_o}, exp_at(idx, v.seed));
          idx++;
        end else begin
          held = 1'b1;
          held_val = {out_re_o, out_im_o};
        end
      end else begin
        gaps++;
      end
      cyc++;
      @(negedge clk_i);
    end
    out_ready_i = 1'b1;
    check(!out_valid_o && !in_ready_o, "R5 idle after last sample",
          {30'd0, out_valid_o, in_ready_o}, 32'd0);
    if (v.stall == 0)
      check(gaps == 0, "R8 continuous output", 32'(gaps), 32'd0);
  endtask

  task automatic busy_start(input vec_t v);
    if (v.restart) begin
      repeat (200) @(negedge clk_i);
      nsym_i  = 8'd5;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      check(1'b1, "R7 busy start issued", 32'd0, 32'd0);
    end
  endtask

  task automatic run_frame(input vec_t v);
    @(negedge clk_i);
    nsym_i  = v.nsym;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    fork
      drive_in(v);
      watch_out(v);
      busy_start(v);
    join
    in_valid_i = 1'b0;
    // frame must stay ended, busy start must not have queued a new one
    repeat (20) @(negedge clk_i);
    check(!out_valid_o, "R7 no frame after ignored start", {31'd0, out_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(!out_valid_o && !in_ready_o, "R1 reset state",
          {30'd0, out_valid_o, in_ready_o}, 32'd0);
    rst_ni = 1'b1;
    in_valid_i = 1'b1;
    in_re_i = 16'hDEAD;
    in_im_i = 16'hBEEF;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      check(!out_valid_o && !in_ready_o, "R1 idle ignores input",
            {30'd0, out_valid_o, in_ready_o}, 32'd0);
    end
    in_valid_i = 1'b0;
    for (int i = 0; i < NVEC; i++) run_frame(VECS[i]);

    // reset in mid-frame returns to quiet state
    @(negedge clk_i);
    nsym_i = 8'd1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (30) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(!out_valid_o && !in_ready_o, "R1 reset mid-frame",
          {30'd0, out_valid_o, in_ready_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule